// File: doc/BRIEF.md
# Floating-Point Exception Flag and Trap Unit

This block sits directly behind the rounding stage of a floating-point pipeline. For each result it receives the operation kind, the destination type and the encoding family of the operands. It also receives the operand classification bits and the status the rounder produced. From these it decides which exception conditions fire. Each fired condition is OR-ed into a sticky status register. When the result underflows, the result word is replaced by an all-zero word. A single trap request is sent toward instruction issue.

Divide-by-zero, invalid, overflow and integer overflow always trap. Underflow and inexact trap only when the instruction sets the matching enable bit. The sticky bits and the zero override do not depend on those enables.

When several conditions fire on the same result, there is still only one trap pulse. The full set of fired conditions is presented with that pulse, so a downstream handler can apply its own priority. Software clears or loads the sticky register with an explicit write strobe.

Top module: `fp_exc_trap_unit`

## Requirements
- R1: All outputs are registered one cycle after the inputs. `out_valid_o` repeats `res_valid_i` one cycle later. A cycle without `res_valid_i` produces no trap and an all-zero `exc_o`. After reset, every output is zero.
- R2: Divide-by-zero in the older (non-IEEE) encoding family (`fmt_ieee_i`=0) fires whenever a divide has a valid numerator and a zero denominator. It always requests a trap.
- R3: Divide-by-zero in IEEE encoding requires a valid, nonzero numerator and a denominator of either sign of zero. In IEEE encoding, a valid zero divided by zero raises invalid and not divide-by-zero. A NaN operand (`nan_i`) also raises invalid. Invalid always requests a trap.
- R4: Overflow fires only for a floating-point destination whose rounder reports a magnitude above the largest finite value. It always requests a trap, and the result word passes through unchanged.
- R5: Underflow fires only for a floating-point destination whose rounder reports a magnitude below the smallest normal value. The result word is then forced to all zeros, a positive zero. A trap is requested only when `trap_unf_en_i` is set.
- R6: Inexact fires when the rounder reports that the result is inexact. A trap is requested only when `trap_ine_en_i` is set. The rounded result is passed through unchanged.
- R7: While `trap_ine_en_i` is set, inexact also fires together with any overflow, underflow or integer overflow.
- R8: Integer overflow fires only for an integer destination whose rounder reports integer overflow. It always requests a trap.
- R9: When divide-by-zero or invalid fires, the rounder status inputs are ignored: overflow, underflow, inexact and integer overflow do not fire, and the result is not zeroed.
- R10: The sticky register keeps every condition that has fired since it was last written. A write with `csr_wr_i` loads `csr_wdata_i`, and conditions firing in the same cycle are OR-ed on top. With neither a valid result nor a write, the register holds its value.
- R11: `exc_o` and the sticky register share one bit layout: bit 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact, 5 integer overflow. Each valid result gives at most one `trap_o` pulse, presented together with every bit that fired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid_i | input | 1 | A rounded result is present this cycle |
| op_div_i | input | 1 | Operation is a divide |
| dst_int_i | input | 1 | Destination is an integer type |
| fmt_ieee_i | input | 1 | 1 = IEEE encoding, 0 = older encoding family |
| num_valid_i | input | 1 | Numerator is a valid operand |
| num_zero_i | input | 1 | Numerator is zero |
| den_zero_i | input | 1 | Denominator is zero (either sign) |
| nan_i | input | 1 | An operand is a NaN |
| rnd_ovf_i | input | 1 | Rounded magnitude exceeds the largest finite value |
| rnd_unf_i | input | 1 | Rounded magnitude is below the smallest normal value |
| rnd_inexact_i | input | 1 | Rounded result differs from the exact result |
| int_ovf_i | input | 1 | Integer conversion overflowed |
| trap_unf_en_i | input | 1 | Instruction enables the underflow trap |
| trap_ine_en_i | input | 1 | Instruction enables the inexact trap |
| result_i | input | DATA_W | Rounded result word |
| csr_wr_i | input | 1 | Load the sticky register |
| csr_wdata_i | input | 6 | Value loaded into the sticky register |
| out_valid_o | output | 1 | Registered result valid |
| result_o | output | DATA_W | Result word after any override |
| trap_o | output | 1 | One-cycle trap request |
| exc_o | output | 6 | Conditions fired on the current result |
| sticky_o | output | 6 | Sticky status register |

## Verification
The assertions assume that every input is a known two-state value after reset and changes only between clock edges. They also assume that the classification and rounder bits describe the same result as `res_valid_i`. Some conditions, such as overflow on a divide by zero, cannot occur in a real pipeline. Apart from that, the assertions do not assume the inputs are mutually consistent. The stimulus drives all inputs on the falling edge. It mixes directed cases for each divide rule, the zeroing and inexact-companion cases, and register writes with long random runs. In those runs every input bit, including the write strobe, toggles independently. Impossible combinations therefore also reach the masking logic.

// File: rtl/fpx_pkg.sv
`timescale 1ns/1ps
package fpx_pkg;
    localparam int EXC_W = 6;
    localparam int X_INV = 0;
    localparam int X_DZE = 1;
    localparam int X_OVF = 2;
    localparam int X_UNF = 3;
    localparam int X_INE = 4;
    localparam int X_IOV = 5;
    typedef logic [EXC_W-1:0] exc_t;
    // conditions that trap regardless of instruction enables
    localparam exc_t ALWAYS_TRAP = exc_t'((1 << X_INV) | (1 << X_DZE) | (1 << X_OVF) | (1 << X_IOV));
endpackage

// File: rtl/fpx_detect.sv
`timescale 1ns/1ps
module fpx_detect
    import fpx_pkg::*;
(
    input  logic op_div_i,
    input  logic dst_int_i,
    input  logic fmt_ieee_i,
    input  logic num_valid_i,
    input  logic num_zero_i,
    input  logic den_zero_i,
    input  logic nan_i,
    input  logic rnd_ovf_i,
    input  logic rnd_unf_i,
    input  logic rnd_inexact_i,
    input  logic int_ovf_i,
    input  logic trap_unf_en_i,
    input  logic trap_ine_en_i,
    output exc_t fired_o,
    output logic trap_req_o
);
    logic inv, dze, arith, ovf, unf, iov, ine;
    exc_t trap_en;

    always_comb begin
        // IEEE 0/0 is an invalid operation, never divide-by-zero
        inv   = nan_i | (fmt_ieee_i & op_div_i & num_valid_i & num_zero_i & den_zero_i);
        dze   = op_div_i & num_valid_i & den_zero_i & (~fmt_ieee_i | ~num_zero_i);
        // rounder status is meaningless once the operation itself faulted
        arith = ~(inv | dze);
        ovf   = arith & ~dst_int_i & rnd_ovf_i;
        unf   = arith & ~dst_int_i & rnd_unf_i;
        iov   = arith &  dst_int_i & int_ovf_i;
        ine   = arith & (rnd_inexact_i | (trap_ine_en_i & (ovf | unf | iov)));
        fired_o        = '0;
        fired_o[X_INV] = inv;
        fired_o[X_DZE] = dze;
        fired_o[X_OVF] = ovf;
        fired_o[X_UNF] = unf;
        fired_o[X_INE] = ine;
        fired_o[X_IOV] = iov;
    end

    for (genvar g = 0; g < EXC_W; g++) begin : g_en
        if (g == X_UNF) begin : g_unf
            assign trap_en[g] = trap_unf_en_i;
        end else if (g == X_INE) begin : g_ine
            assign trap_en[g] = trap_ine_en_i;
        end else begin : g_fix
            assign trap_en[g] = ALWAYS_TRAP[g];
        end
    end

    assign trap_req_o = |(fired_o & trap_en);
endmodule

// File: rtl/fpx_status.sv
`timescale 1ns/1ps
module fpx_status
    import fpx_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  exc_t              fired_i,
    input  logic              trap_req_i,
    input  logic [DATA_W-1:0] result_i,
    input  logic              csr_wr_i,
    input  exc_t              csr_wdata_i,
    output logic              valid_o,
    output logic              trap_o,
    output exc_t              exc_o,
    output exc_t              sticky_o,
    output logic [DATA_W-1:0] result_o
);
    typedef struct packed {
        logic              vld;
        logic              trap;
        exc_t              exc;
        exc_t              sticky;
        logic [DATA_W-1:0] res;
    } st_t;

    st_t st_d, st_q;
    exc_t fired_v;

    always_comb begin
        fired_v     = valid_i ? fired_i : '0;
        st_d        = st_q;
        st_d.vld    = valid_i;
        st_d.trap   = valid_i & trap_req_i;
        st_d.exc    = fired_v;
        st_d.sticky = (csr_wr_i ? csr_wdata_i : st_q.sticky) | fired_v;
        // underflow flushes to an all-zero (positive) word
        st_d.res    = fired_v[X_UNF] ? '0 : result_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o  = st_q.vld;
    assign trap_o   = st_q.trap;
    assign exc_o    = st_q.exc;
    assign sticky_o = st_q.sticky;
    assign result_o = st_q.res;

    a_r11_trap_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> valid_o);
    a_r10_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && !csr_wr_i) |=> $stable(sticky_o));
    a_r10_sticky_covers: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((sticky_o & exc_o) == exc_o));
endmodule

// File: rtl/fp_exc_trap_unit.sv
`timescale 1ns/1ps
module fp_exc_trap_unit
    import fpx_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid_i,
    input  logic              op_div_i,
    input  logic              dst_int_i,
    input  logic              fmt_ieee_i,
    input  logic              num_valid_i,
    input  logic              num_zero_i,
    input  logic              den_zero_i,
    input  logic              nan_i,
    input  logic              rnd_ovf_i,
    input  logic              rnd_unf_i,
    input  logic              rnd_inexact_i,
    input  logic              int_ovf_i,
    input  logic              trap_unf_en_i,
    input  logic              trap_ine_en_i,
    input  logic [DATA_W-1:0] result_i,
    input  logic              csr_wr_i,
    input  logic [5:0]        csr_wdata_i,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] result_o,
    output logic              trap_o,
    output logic [5:0]        exc_o,
    output logic [5:0]        sticky_o
);
    exc_t fired;
    logic trap_req;

    fpx_detect u_detect (
        .op_div_i      (op_div_i),
        .dst_int_i     (dst_int_i),
        .fmt_ieee_i    (fmt_ieee_i),
        .num_valid_i   (num_valid_i),
        .num_zero_i    (num_zero_i),
        .den_zero_i    (den_zero_i),
        .nan_i         (nan_i),
        .rnd_ovf_i     (rnd_ovf_i),
        .rnd_unf_i     (rnd_unf_i),
        .rnd_inexact_i (rnd_inexact_i),
        .int_ovf_i     (int_ovf_i),
        .trap_unf_en_i (trap_unf_en_i),
        .trap_ine_en_i (trap_ine_en_i),
        .fired_o       (fired),
        .trap_req_o    (trap_req)
    );

    fpx_status #(.DATA_W(DATA_W)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (res_valid_i),
        .fired_i     (fired),
        .trap_req_i  (trap_req),
        .result_i    (result_i),
        .csr_wr_i    (csr_wr_i),
        .csr_wdata_i (csr_wdata_i),
        .valid_o     (out_valid_o),
        .trap_o      (trap_o),
        .exc_o       (exc_o),
        .sticky_o    (sticky_o),
        .result_o    (result_o)
    );

    a_r2_dze_traps: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o[X_DZE] |-> trap_o);
    a_r3_zero_over_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_i && op_div_i && fmt_ieee_i && num_valid_i && num_zero_i && den_zero_i)
        |=> (exc_o[X_INV] && !exc_o[X_DZE]));
    a_r4_int_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_i && dst_int_i) |=> !exc_o[X_OVF]);
    a_r5_unf_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && exc_o[X_UNF]) |-> (result_o == '0));
    a_r7_ine_companion: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_i && trap_ine_en_i && !dst_int_i && rnd_ovf_i && !op_div_i && !nan_i)
        |=> exc_o[X_INE]);
endmodule

// File: tb/sim_fp_exc_trap_unit.sv
`timescale 1ns/1ps
module sim_fp_exc_trap_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic res_valid_i = 0, op_div_i = 0, dst_int_i = 0, fmt_ieee_i = 0;
    logic num_valid_i = 0, num_zero_i = 0, den_zero_i = 0, nan_i = 0;
    logic rnd_ovf_i = 0, rnd_unf_i = 0, rnd_inexact_i = 0, int_ovf_i = 0;
    logic trap_unf_en_i = 0, trap_ine_en_i = 0, csr_wr_i = 0;
    logic [63:0] result_i = '0;
    logic [5:0] csr_wdata_i = '0;
    logic out_valid_o, trap_o;
    logic [63:0] result_o;
    logic [5:0] exc_o, sticky_o;

    int checks = 0;
    int errors = 0;
    logic [5:0] m_sticky = '0;
    logic e_vld, e_trap;
    logic [5:0] e_exc;
    logic [63:0] e_res;

    always #2 clk = ~clk;

    fp_exc_trap_unit u0 (.*);

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural model of the requirements; bit order per R11
    task automatic predict();
        logic inv, dze, ovf, unf, ine, iov, trap;
        inv = 0; dze = 0; ovf = 0; unf = 0; ine = 0; iov = 0;
        if (nan_i) inv = 1;
        if (op_div_i && num_valid_i && den_zero_i) begin
            if (!fmt_ieee_i) dze = 1;                  // R2
            else if (num_zero_i) inv = 1;              // R3
            else dze = 1;
        end
        if (!inv && !dze) begin                        // R9
            if (dst_int_i) iov = int_ovf_i;            // R8
            else begin ovf = rnd_ovf_i; unf = rnd_unf_i; end
            ine = rnd_inexact_i || (trap_ine_en_i && (ovf || unf || iov)); // R6 R7
        end
        trap = inv || dze || ovf || iov || (unf && trap_unf_en_i) || (ine && trap_ine_en_i);
        e_vld = res_valid_i;
        if (res_valid_i) begin
            e_exc  = {iov, ine, unf, ovf, dze, inv};
            e_trap = trap;
            e_res  = unf ? 64'd0 : result_i;
        end else begin
            e_exc = '0; e_trap = 0; e_res = 'x;
        end
        if (csr_wr_i) m_sticky = csr_wdata_i;
        m_sticky = m_sticky | e_exc;
    endtask

    task automatic step();
        predict();
        @(negedge clk);
        chk("R1 out_valid", 64'(out_valid_o), 64'(e_vld));
        chk("R11 trap pulse", 64'(trap_o), 64'(e_trap));
        chk("exc R2 R3 R4 R5 R6 R7 R8 R9 R11", 64'(exc_o), 64'(e_exc));
        chk("R10 sticky", 64'(sticky_o), 64'(m_sticky));
        if (e_vld) chk("R5 result", result_o, e_res);
    endtask

    task automatic clr();
        res_valid_i = 1; op_div_i = 0; dst_int_i = 0; fmt_ieee_i = 0;
        num_valid_i = 1; num_zero_i = 0; den_zero_i = 0; nan_i = 0;
        rnd_ovf_i = 0; rnd_unf_i = 0; rnd_inexact_i = 0; int_ovf_i = 0;
        trap_unf_en_i = 0; trap_ine_en_i = 0; csr_wr_i = 0; csr_wdata_i = '0;
        result_i = 64'h8000_0000_0000_0000;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset valid", 64'(out_valid_o), 64'd0);
        chk("R1 reset trap", 64'(trap_o), 64'd0);
        chk("R10 reset sticky", 64'(sticky_o), 64'd0);
        rst_n = 1;
        // R2: older family 0/0 is divide-by-zero
        clr(); op_div_i = 1; num_zero_i = 1; den_zero_i = 1; step();
        // R3: IEEE 0/0 is invalid
        clr(); op_div_i = 1; fmt_ieee_i = 1; num_zero_i = 1; den_zero_i = 1; step();
        // R3: IEEE x/0 is divide-by-zero; R9 rounder ignored
        clr(); op_div_i = 1; fmt_ieee_i = 1; den_zero_i = 1; rnd_unf_i = 1; rnd_inexact_i = 1; step();
        // R10: write clears sticky
        clr(); res_valid_i = 0; csr_wr_i = 1; step();
        // R4: overflow on float dest, result passes
        clr(); rnd_ovf_i = 1; result_i = 64'h7ff0_1234_0000_0001; step();
        // R4 R8: int dest never overflows as float
        clr(); dst_int_i = 1; rnd_ovf_i = 1; int_ovf_i = 1; step();
        // R5: underflow zeroes, no trap without enable
        clr(); rnd_unf_i = 1; step();
        // R5: with enable, trap
        clr(); rnd_unf_i = 1; trap_unf_en_i = 1; step();
        // R6: inexact without enable: no trap, result kept
        clr(); rnd_inexact_i = 1; result_i = 64'h3ff0_0000_0000_0003; step();
        clr(); rnd_inexact_i = 1; trap_ine_en_i = 1; step();
        // R7: companion inexact
        clr(); rnd_unf_i = 1; trap_ine_en_i = 1; step();
        clr(); dst_int_i = 1; int_ovf_i = 1; trap_ine_en_i = 1; step();
        // R3: NaN operand
        clr(); nan_i = 1; step();
        // R10: write with simultaneous event
        clr(); csr_wr_i = 1; csr_wdata_i = 6'b100000; rnd_ovf_i = 1; step();
        // R1: idle cycle, sticky held
        clr(); res_valid_i = 0; rnd_ovf_i = 1; step();
        // random
        for (int i = 0; i < 3000; i++) begin
            res_valid_i = $urandom_range(0, 3) != 0;
            {op_div_i, dst_int_i, fmt_ieee_i, num_valid_i, num_zero_i, den_zero_i} = 6'($urandom);
            nan_i = $urandom_range(0, 7) == 0;
            {rnd_ovf_i, rnd_unf_i, rnd_inexact_i, int_ovf_i} = 4'($urandom);
            {trap_unf_en_i, trap_ine_en_i} = 2'($urandom);
            csr_wr_i = $urandom_range(0, 15) == 0;
            csr_wdata_i = 6'($urandom);
            result_i = {$urandom, $urandom};
            step();
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule